// File: doc/BRIEF.md
# System Error Reporting Control

This block sits beside the posted-write path of a bridge. It decides whether an error seen there is reported to the system as a system error (SERR). Three error events come in on a small vector, one strobe per event and cycle: a parity error on the target bus during a posted write, a retry-timer expiry while a posted write is still pending, and a target abort received during a posted write. Each event has its own disable bit and its own sticky status bit. A global enable bit in the command register gates whether any event reaches the active-low `serr_n` output.

Software reaches the block through a simple register port. Writes take effect at the clock edge, and reads are combinational from the byte offset. Four 16-bit registers are decoded, and every other offset reads as zero. When the block drives SERR, it also records that fact in a flag in the secondary status register. The status bits and this flag are cleared by writing ones. Detecting the errors themselves is the job of the datapath and is not part of this block.

The register port carries no data stream. It is a plain control path with no back-pressure: every write is accepted in the cycle it is presented.

Top module: `serr_report_ctrl`

## Requirements
- R1: After reset, the command, event-disable, status and secondary status registers all read 0, and `serr_n` is high.
- R2: The command register at offset 04h implements only bit 8, the global SERR enable. Bit 8 is read/write and every other bit reads 0.
- R3: The event-disable register at offset 64h implements bits 1, 2 and 3. They are read/write and map to parity (err_evt[0]), timeout (err_evt[1]) and target abort (err_evt[2]). Every other bit reads 0.
- R4: An event in a cycle whose disable bit is 0 sets the matching status bit at offset 6Ah at that clock edge (bit 1 for parity, bit 2 for timeout, bit 3 for target abort). The global enable has no bearing on this.
- R5: An event whose disable bit is 1 sets no status bit and does not drive `serr_n` low.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: When an event and a write-one-to-clear of its status bit fall in the same cycle, the bit ends up set.
- R8: `serr_n` is low for exactly the one cycle after each cycle that holds at least one enabled event while command bit 8 is 1. It is high in every other cycle.
- R9: Bit 14 of the secondary status register at offset 1Eh is set at every edge where SERR is signaled. It clears when 1 is written to it, and a new signal in the same cycle as that write wins.
- R10: Every offset other than 04h, 1Eh, 64h and 6Ah reads 0. Writes to those other offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| err_evt | input | N_EVT (3) | Event strobes: [0] parity, [1] retry timeout, [2] target abort |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Read data for reg_addr, combinational |
| serr_n | output | 1 | System error output, active low, one cycle per report |

## Verification
The hardest case to reach from the ports is an event landing in the same cycle as a write-one-to-clear of the status register or the secondary flag. The bench first loads every status bit. It then drives, in one cycle, every combination of clear mask and event vector, and reads the result back to compare it with (old & ~mask) | event. A second sweep covers the global enable, all eight disable patterns and all eight event patterns. In each case it checks the status bits and the secondary flag, and it checks that the SERR pulse lasts exactly one cycle.

// File: rtl/serr_pkg.sv
package serr_pkg;
  localparam int unsigned REG_W        = 16;
  localparam int unsigned OFS_W        = 8;
  localparam int unsigned EVT_COUNT    = 3;
  localparam int unsigned EVT_LSB      = 1;
  localparam int unsigned CMD_SERR_BIT = 8;
  localparam int unsigned SEC_SERR_BIT = 14;

  localparam logic [OFS_W-1:0] OFS_CMD  = 8'h04;
  localparam logic [OFS_W-1:0] OFS_SEC  = 8'h1E;
  localparam logic [OFS_W-1:0] OFS_DIS  = 8'h64;
  localparam logic [OFS_W-1:0] OFS_STAT = 8'h6A;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMD,
    SEL_SEC,
    SEL_DIS,
    SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/serr_addr_dec.sv
module serr_addr_dec #(
  parameter int unsigned ADDR_W = serr_pkg::OFS_W
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  output serr_pkg::reg_sel_e sel,
  output logic              we_cmd,
  output logic              we_dis,
  output logic              we_stat,
  output logic              we_sec
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(serr_pkg::OFS_CMD);
  localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(serr_pkg::OFS_SEC);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(serr_pkg::OFS_DIS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(serr_pkg::OFS_STAT);

  always_comb begin
    if (reg_addr == A_CMD)       sel = serr_pkg::SEL_CMD;
    else if (reg_addr == A_SEC)  sel = serr_pkg::SEL_SEC;
    else if (reg_addr == A_DIS)  sel = serr_pkg::SEL_DIS;
    else if (reg_addr == A_STAT) sel = serr_pkg::SEL_STAT;
    else                         sel = serr_pkg::SEL_NONE;
  end

  assign we_cmd  = reg_wr && (sel == serr_pkg::SEL_CMD);
  assign we_dis  = reg_wr && (sel == serr_pkg::SEL_DIS);
  assign we_stat = reg_wr && (sel == serr_pkg::SEL_STAT);
  assign we_sec  = reg_wr && (sel == serr_pkg::SEL_SEC);
endmodule

// File: rtl/serr_ctrl_regs.sv
module serr_ctrl_regs #(
  parameter int unsigned N_EVT = serr_pkg::EVT_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_cmd,
  input  logic             we_dis,
  input  logic             wr_serr_en,
  input  logic [N_EVT-1:0] wr_dis,
  output logic             serr_en_q,
  output logic [N_EVT-1:0] dis_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serr_en_q <= 1'b0;
    end else if (we_cmd) begin
      serr_en_q <= wr_serr_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= '0;
    end else if (we_dis) begin
      dis_q <= wr_dis;
    end
  end
endmodule

// File: rtl/serr_evt_status.sv
module serr_evt_status #(
  parameter int unsigned N_EVT = serr_pkg::EVT_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] err_evt,
  input  logic [N_EVT-1:0] dis_q,
  input  logic             we_stat,
  input  logic [N_EVT-1:0] clr_mask,
  output logic [N_EVT-1:0] stat_q,
  output logic             any_report
);
  logic [N_EVT-1:0] live;

  assign live       = err_evt & ~dis_q;
  assign any_report = |live;

  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    logic clr_i;
    assign clr_i = we_stat && clr_mask[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[i] <= 1'b0;
      end else if (live[i]) begin
        stat_q[i] <= 1'b1;
      end else if (clr_i) begin
        stat_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serr_signal_gen.sv
module serr_signal_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic any_report,
  input  logic serr_en_q,
  input  logic we_sec,
  input  logic sec_clr_bit,
  output logic serr_n,
  output logic sec_flag_q
);
  logic fire;

  assign fire = any_report && serr_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serr_n <= 1'b1;
    end else begin
      serr_n <= !fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_flag_q <= 1'b0;
    end else if (fire) begin
      sec_flag_q <= 1'b1;
    end else if (we_sec && sec_clr_bit) begin
      sec_flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/serr_report_ctrl.sv
module serr_report_ctrl #(
  parameter int unsigned N_EVT  = serr_pkg::EVT_COUNT,
  parameter int unsigned ADDR_W = serr_pkg::OFS_W,
  parameter int unsigned DATA_W = serr_pkg::REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  err_evt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              serr_n
);
  localparam int unsigned EVT_LSB  = serr_pkg::EVT_LSB;
  localparam int unsigned CMD_BIT  = serr_pkg::CMD_SERR_BIT;
  localparam int unsigned SEC_BIT  = serr_pkg::SEC_SERR_BIT;

  serr_pkg::reg_sel_e sel;
  logic               we_cmd, we_dis, we_stat, we_sec;
  logic               serr_en_q;
  logic [N_EVT-1:0]   dis_q;
  logic [N_EVT-1:0]   stat_q;
  logic               any_report;
  logic               sec_flag_q;

  serr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .sel     (sel),
    .we_cmd  (we_cmd),
    .we_dis  (we_dis),
    .we_stat (we_stat),
    .we_sec  (we_sec)
  );

  serr_ctrl_regs #(.N_EVT(N_EVT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_cmd    (we_cmd),
    .we_dis    (we_dis),
    .wr_serr_en(reg_wdata[CMD_BIT]),
    .wr_dis    (reg_wdata[EVT_LSB +: N_EVT]),
    .serr_en_q (serr_en_q),
    .dis_q     (dis_q)
  );

  serr_evt_status #(.N_EVT(N_EVT)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_evt   (err_evt),
    .dis_q     (dis_q),
    .we_stat   (we_stat),
    .clr_mask  (reg_wdata[EVT_LSB +: N_EVT]),
    .stat_q    (stat_q),
    .any_report(any_report)
  );

  serr_signal_gen u_sig (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_report (any_report),
    .serr_en_q  (serr_en_q),
    .we_sec     (we_sec),
    .sec_clr_bit(reg_wdata[SEC_BIT]),
    .serr_n     (serr_n),
    .sec_flag_q (sec_flag_q)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      serr_pkg::SEL_CMD:  reg_rdata[CMD_BIT] = serr_en_q;
      serr_pkg::SEL_SEC:  reg_rdata[SEC_BIT] = sec_flag_q;
      serr_pkg::SEL_DIS:  reg_rdata[EVT_LSB +: N_EVT] = dis_q;
      serr_pkg::SEL_STAT: reg_rdata[EVT_LSB +: N_EVT] = stat_q;
      default:            reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/serr_report_ctrl_sva.sv
module serr_report_ctrl_sva #(
  parameter int unsigned N_EVT  = 3,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_EVT-1:0]  err_evt,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              serr_n,
  input logic              serr_en_q,
  input logic [N_EVT-1:0]  dis_q,
  input logic [N_EVT-1:0]  stat_q,
  input logic              sec_flag_q
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(serr_pkg::OFS_STAT);

  assert_status_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_evt & ~dis_q) != '0) |=>
      ((stat_q & $past(err_evt & ~dis_q)) == $past(err_evt & ~dis_q)));

  assert_no_disabled_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(err_evt & ~dis_q)) == '0));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_pulse_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (serr_en_q && ((err_evt & ~dis_q) != '0)) |=> !serr_n);

  assert_pulse_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(serr_en_q && ((err_evt & ~dis_q) != '0)) |=> serr_n);

  assert_sec_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> sec_flag_q);
endmodule

bind serr_report_ctrl serr_report_ctrl_sva #(.N_EVT(N_EVT), .ADDR_W(ADDR_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_evt   (err_evt),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .serr_n    (serr_n),
  .serr_en_q (serr_en_q),
  .dis_q     (dis_q),
  .stat_q    (stat_q),
  .sec_flag_q(sec_flag_q)
);

// File: tb/serr_report_ctrl_tb.sv
module serr_report_ctrl_tb;
  localparam logic [7:0] A_CMD  = 8'h04;
  localparam logic [7:0] A_SEC  = 8'h1E;
  localparam logic [7:0] A_DIS  = 8'h64;
  localparam logic [7:0] A_STAT = 8'h6A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  err_evt = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        serr_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serr_report_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .serr_n(serr_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic preload_all();
    wr(A_CMD, 16'h0100);
    wr(A_DIS, 16'h0000);
    @(negedge clk); err_evt = 3'b111;
    @(negedge clk); err_evt = 3'b000;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 serr_n", {15'd0, serr_n}, 16'd1);
    rd(A_CMD, v);  chk("R1 cmd", v, 16'h0000);
    rd(A_DIS, v);  chk("R1 dis", v, 16'h0000);
    rd(A_STAT, v); chk("R1 stat", v, 16'h0000);
    rd(A_SEC, v);  chk("R1 sec", v, 16'h0000);

    // R2 / R3 implemented bits
    wr(A_CMD, 16'hFFFF); rd(A_CMD, v); chk("R2 cmd all ones", v, 16'h0100);
    wr(A_CMD, 16'hFEFF); rd(A_CMD, v); chk("R2 cmd bit8 clear", v, 16'h0000);
    wr(A_DIS, 16'hFFFF); rd(A_DIS, v); chk("R3 dis all ones", v, 16'h000E);
    wr(A_DIS, 16'h0004); rd(A_DIS, v); chk("R3 dis one bit", v, 16'h0004);
    wr(A_DIS, 16'h0000);

    // R10 unimplemented offsets
    for (int a = 0; a < 256; a += 2) begin
      if (a[7:0] != A_CMD && a[7:0] != A_SEC && a[7:0] != A_DIS && a[7:0] != A_STAT) begin
        wr(a[7:0], 16'hFFFF);
        rd(a[7:0], v); chk("R10 unimplemented reads 0", v, 16'h0000);
      end
    end
    rd(A_CMD, v); chk("R10 cmd untouched", v, 16'h0000);
    rd(A_DIS, v); chk("R10 dis untouched", v, 16'h0000);
    rd(A_STAT, v); chk("R10 stat untouched", v, 16'h0000);
    rd(A_SEC, v); chk("R10 sec untouched", v, 16'h0000);

    // R4 R5 R8 R9 sweep over enable, disable mask and event vector
    for (int c = 0; c < 2; c++) begin
      for (int d = 0; d < 8; d++) begin
        for (int e = 0; e < 8; e++) begin
          logic [2:0] rep;
          logic       sig;
          wr(A_STAT, 16'hFFFF);
          wr(A_SEC, 16'hFFFF);
          wr(A_CMD, c[0] ? 16'h0100 : 16'h0000);
          wr(A_DIS, {12'd0, d[2:0], 1'b0});
          @(negedge clk); err_evt = e[2:0];
          @(negedge clk); err_evt = 3'b000;
          rep = e[2:0] & ~d[2:0];
          sig = c[0] && (rep != 3'b000);
          chk("R8 serr_n pulse", {15'd0, serr_n}, {15'd0, !sig});
          rd(A_STAT, v); chk("R4/R5 status", v, {12'd0, rep, 1'b0});
          rd(A_SEC, v);  chk("R9 sec flag", v, {1'b0, sig, 14'd0});
          @(negedge clk);
          chk("R8 single cycle", {15'd0, serr_n}, 16'd1);
        end
      end
    end

    // R8 back-to-back events give back-to-back low cycles
    wr(A_CMD, 16'h0100); wr(A_DIS, 16'h0000);
    @(negedge clk); err_evt = 3'b001;
    @(negedge clk); err_evt = 3'b100;
    chk("R8 first of two", {15'd0, serr_n}, 16'd0);
    @(negedge clk); err_evt = 3'b000;
    chk("R8 second of two", {15'd0, serr_n}, 16'd0);
    @(negedge clk);
    chk("R8 after two", {15'd0, serr_n}, 16'd1);

    // R6 / R7 clear mask against simultaneous events
    for (int m = 0; m < 8; m++) begin
      for (int e = 0; e < 8; e++) begin
        preload_all();
        @(negedge clk);
        err_evt = e[2:0]; reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = {12'd0, m[2:0], 1'b0};
        @(negedge clk);
        err_evt = 3'b000; reg_wr = 1'b0;
        rd(A_STAT, v);
        chk(m == 0 ? "R6 write zero keeps" : "R6/R7 clear vs set", v,
            {12'd0, (3'b111 & ~m[2:0]) | e[2:0], 1'b0});
      end
    end

    // R9 flag clear versus new signal in the same cycle
    for (int e = 0; e < 2; e++) begin
      preload_all();
      @(negedge clk);
      err_evt = {2'b00, e[0]}; reg_wr = 1'b1; reg_addr = A_SEC; reg_wdata = 16'h4000;
      @(negedge clk);
      err_evt = 3'b000; reg_wr = 1'b0;
      rd(A_SEC, v); chk("R9 clear vs set", v, {1'b0, e[0], 14'd0});
    end
    preload_all();
    wr(A_SEC, 16'hBFFF); rd(A_SEC, v); chk("R9 write zero keeps", v, 16'h4000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule